// File: doc/BRIEF.md
# Multidrop Serial Receive Engine

This block recovers characters from an asynchronous serial line. A one-cycle clock enable, pulsing at sixteen times the bit rate, paces an oversampling state machine. A falling edge on the idle-high line starts a character, and the engine checks the start bit again at its midpoint. It then takes 5 to 8 data bits with the least significant bit first, an optional parity bit and one stop bit. Each completed character goes into a small show-ahead FIFO. The host pops the FIFO one byte at a time and reads a status word that carries a data-ready flag and sticky error flags.

The engine also has a 9-bit multidrop mode for shared buses. In this mode the ninth bit of every character tells address from data. A 1 in that position (mark) marks an address byte. The engine stores it and raises the address flag and the interrupt line. The host compares the address with its own and then drives `md_ignore` high or low. While `md_ignore` is high, data bytes (ninth bit 0, space) are dropped, but address bytes still arrive.

Top module: `mdrop_uart_rx`

## Requirements
- R1: Each bit is sampled on the 8th tick-enable pulse of its 16-tick bit time, counted from the tick where the falling start edge is seen. If the start bit reads high at its midpoint, it is a glitch: nothing is stored and the engine goes back to idle. Data bits arrive least significant bit first.
- R2: `cfg_len` selects the character length: 0→5, 1→6, 2→7, 3→8 data bits. Unused upper bits of `rx_byte` read as zero.
- R3: `status[0]` (data ready) is 1 whenever the FIFO holds at least one byte. A pulse on `rd_data` removes the byte shown on `rx_byte`. The flag clears only once every stored byte has been read.
- R4: With `md_en`=0 and `par_en`=1, one parity bit follows the data. It is even parity when `par_odd`=0 and odd parity when `par_odd`=1. A mismatch sets `status[2]`, and the byte is still stored.
- R5: A stop bit sampled low sets `status[3]` (framing), unless the character is a break. The byte is still stored.
- R6: A break is a character in which start, data, parity (if present) and stop bits all sample low. It sets `status[4]`, leaves `status[3]` clear, and stores exactly one 0x00 byte. No new character starts until the line has gone high again.
- R7: If a character completes while the FIFO is full, `status[1]` (overrun) is set, the new byte is dropped, and the stored bytes stay unchanged and in order.
- R8: With `md_en`=1, a ninth bit is always present and the parity setting is not used. A 1 in the ninth bit sets `status[5]` (address) and the byte is stored. No parity error is ever flagged in this mode.
- R9: With `md_en`=1 and `md_ignore`=1, characters whose ninth bit is 0 are not stored. Address characters are stored as usual. With `md_ignore`=0, data characters are stored.
- R10: Status bits 1 to 5 are sticky and clear on a `rd_lsr` pulse. A flag set in the same cycle as the pulse wins. `irq` is 1 whenever any of bits 1 to 5 is set.
- R11: After reset, `status` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Character length code (5 + value) |
| par_en | input | 1 | Parity bit present (normal mode) |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| md_en | input | 1 | 9-bit multidrop mode |
| md_ignore | input | 1 | Drop data bytes in multidrop mode |
| rd_data | input | 1 | Pop the head byte |
| rd_lsr | input | 1 | Status read, clears sticky flags |
| rx_byte | output | 8 | Head byte of the FIFO |
| status | output | 8 | {2'b0, addr, break, framing, parity, overrun, ready} |
| irq | output | 1 | Line-status interrupt |

## Verification
The assertions check on every cycle that a start bit high at its midpoint sends the engine back to idle and that a break always delivers a zero byte. They also check that the FIFO is never written while full or read while empty, that every completion with a full FIFO sets the overrun flag, and that data ready only falls after a pop. Only the bench scenarios can show the end-to-end results: correct bit order and masking for each character length, a parity verdict of each sense, the framing-versus-break classification, which bytes survive an overrun, and the address-then-gate sequence of multidrop mode.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       ferr;
    logic       perr;
    logic       brk;
    logic       addr;
    logic       keep;
  } rx_result_t;

  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_OVR   = 1;
  localparam int unsigned ST_PAR   = 2;
  localparam int unsigned ST_FRM   = 3;
  localparam int unsigned ST_BRK   = 4;
  localparam int unsigned ST_ADDR  = 5;
endpackage

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       md_en,
  input  logic       md_ignore,
  output logic       done,
  output rx_result_t res
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e  state_q, state_n;
  logic [CW-1:0] tcnt_q, tcnt_n;
  logic [2:0] bcnt_q, bcnt_n;
  logic [7:0] sh_q, sh_n;
  logic       par_q, par_n;
  logic       zero_q, zero_n;
  logic       prev_q, prev_n;
  logic       done_n;
  rx_result_t res_n;
  logic [7:0] aligned;
  logic [2:0] last_bit;

  assign last_bit = {1'b0, cfg_len} + 3'd4;

  always_comb begin
    case (cfg_len)
      2'd0:    aligned = {3'b000, sh_q[7:3]};
      2'd1:    aligned = {2'b00, sh_q[7:2]};
      2'd2:    aligned = {1'b0, sh_q[7:1]};
      default: aligned = sh_q;
    endcase
  end

  always_comb begin
    state_n = state_q;
    tcnt_n  = tcnt_q;
    bcnt_n  = bcnt_q;
    sh_n    = sh_q;
    par_n   = par_q;
    zero_n  = zero_q;
    prev_n  = prev_q;
    done_n  = 1'b0;
    res_n   = res;
    if (tick) begin
      prev_n = rxd;
      if (state_q != S_IDLE) tcnt_n = tcnt_q + 1'b1;
      case (state_q)
        S_IDLE: begin
          if (prev_q && !rxd) begin
            state_n = S_START;
            tcnt_n  = '0;
          end
        end
        S_START: begin
          if (tcnt_q == MID) begin
            tcnt_n = '0;
            if (rxd) begin
              state_n = S_IDLE;
            end else begin
              state_n = S_DATA;
              bcnt_n  = 3'd0;
              zero_n  = 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tcnt_q == LAST) begin
            sh_n   = {rxd, sh_q[7:1]};
            zero_n = zero_q & ~rxd;
            if (bcnt_q == last_bit) begin
              state_n = (par_en || md_en) ? S_PAR : S_STOP;
            end else begin
              bcnt_n = bcnt_q + 3'd1;
            end
          end
        end
        S_PAR: begin
          if (tcnt_q == LAST) begin
            par_n   = rxd;
            zero_n  = zero_q & ~rxd;
            state_n = S_STOP;
          end
        end
        S_STOP: begin
          if (tcnt_q == LAST) begin
            state_n    = S_IDLE;
            done_n     = 1'b1;
            res_n.brk  = zero_q & ~rxd;
            res_n.ferr = ~rxd & ~(zero_q & ~rxd);
            res_n.data = res_n.brk ? 8'h00 : aligned;
            if (md_en) begin
              res_n.perr = 1'b0;
              res_n.addr = par_q & ~res_n.brk;
              res_n.keep = res_n.brk | par_q | ~md_ignore;
            end else begin
              res_n.addr = 1'b0;
              res_n.keep = 1'b1;
              res_n.perr = par_en & ~res_n.brk & (par_q != (^aligned ^ par_odd));
            end
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      prev_q  <= 1'b1;
      done    <= 1'b0;
      res     <= '0;
    end else begin
      state_q <= state_n;
      tcnt_q  <= tcnt_n;
      bcnt_q  <= bcnt_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      zero_q  <= zero_n;
      prev_q  <= prev_n;
      done    <= done_n;
      res     <= res_n;
    end
  end

  // R1
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && tick && tcnt_q == MID && rxd) |=> (state_q == S_IDLE && !done));

  // R6
  break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res.brk) |-> (res.data == 8'h00 && !res.ferr && res.keep));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_n, rptr_q, rptr_n;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign rdata = mem[rptr_q[AW-1:0]];

  always_comb begin
    wptr_n = push ? wptr_q + 1'b1 : wptr_q;
    rptr_n = pop  ? rptr_q + 1'b1 : rptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q[AW-1:0]] <= wdata;
  end

  // R7
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);

  // R3
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned OVS        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       md_en,
  input  logic       md_ignore,
  input  logic       rd_data,
  input  logic       rd_lsr,
  output logic [7:0] rx_byte,
  output logic [7:0] status,
  output logic       irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic       rxd_s;
  logic       done;
  rx_result_t res;
  logic       empty, full, push, pop;
  logic [5:1] flag_q, flag_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd_s),
    .cfg_len(cfg_len), .par_en(par_en), .par_odd(par_odd),
    .md_en(md_en), .md_ignore(md_ignore), .done(done), .res(res)
  );

  assign push = done & res.keep & ~full;
  assign pop  = rd_data & ~empty;

  rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(res.data),
    .pop(pop), .rdata(rx_byte), .empty(empty), .full(full)
  );

  always_comb begin
    flag_n = rd_lsr ? '0 : flag_q;
    if (done) begin
      if (res.keep && full) flag_n[ST_OVR] = 1'b1;
      if (res.perr)         flag_n[ST_PAR] = 1'b1;
      if (res.ferr)         flag_n[ST_FRM] = 1'b1;
      if (res.brk)          flag_n[ST_BRK] = 1'b1;
      if (res.addr)         flag_n[ST_ADDR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  assign status = {2'b00, flag_q, ~empty};
  assign irq    = |flag_q;

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res.keep && full) |=> status[ST_OVR]);

  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_READY]) |-> $past(pop));
endmodule

// File: tb/test_mdrop_uart_rx.sv
module test_mdrop_uart_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK = 32;

  logic clk = 1'b0;
  logic rst_n, tick16, rxd, par_en, par_odd, md_en, md_ignore, rd_data, rd_lsr;
  logic [1:0] cfg_len;
  logic [7:0] rx_byte, status;
  logic irq;
  int checks = 0, fails = 0;
  logic mon_en;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrop_uart_rx i_mdrop_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .par_en(par_en), .par_odd(par_odd), .md_en(md_en), .md_ignore(md_ignore),
    .rd_data(rd_data), .rd_lsr(rd_lsr), .rx_byte(rx_byte), .status(status), .irq(irq)
  );

  initial begin
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      tick16 = ~tick16;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: pops the FIFO and compares against the scoreboard queue
  task automatic pop_compare(input string req);
    check(rx_byte == expq[0], req, rx_byte, expq[0]);
    void'(expq.pop_front());
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && expq.size() > 0 && status[0]) pop_compare("R1/R2 byte");
    end
  end

  task automatic line_bit(input bit b);
    @(negedge clk);
    rxd = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  // driver: pushes the expected byte, then drives one character
  task automatic send(input logic [7:0] d, input int nb, input bit has_par, input bit pv,
                      input bit stop_v, input bit exp_push);
    if (exp_push) expq.push_back(d & 8'((1 << nb) - 1));
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (has_par) line_bit(pv);
    line_bit(stop_v);
    line_bit(1'b1);
  endtask

  task automatic lsr_read();
    @(negedge clk);
    rd_lsr = 1'b1;
    @(negedge clk);
    rd_lsr = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expq.size() > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; cfg_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    md_en = 1'b0; md_ignore = 1'b0; rd_data = 1'b0; rd_lsr = 1'b0; mon_en = 1'b1;
    repeat (4) @(negedge clk);
    // R11
    check(status == 8'h00, "R11 status after reset", status, 0);
    check(irq == 1'b0, "R11 irq after reset", irq, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R1: 8-bit characters, LSB first
    send(8'hA5, 8, 0, 0, 1, 1);
    send(8'h3C, 8, 0, 0, 1, 1);
    drain();
    check(expq.size() == 0 && status[0] == 0, "R1 all bytes received", expq.size(), 0);

    // R2: 5-bit and 6-bit characters mask the upper bits
    cfg_len = 2'd0;
    send(8'hF5, 5, 0, 0, 1, 1);
    cfg_len = 2'd1;
    send(8'hEA, 6, 0, 0, 1, 1);
    drain();
    check(irq == 0, "R2 no error on short chars", irq, 0);

    // R4: 7-bit even parity good, then bad; odd parity good
    cfg_len = 2'd2; par_en = 1'b1;
    send(8'h55, 7, 1, ^(7'h55), 1, 1);
    drain();
    check(status[2] == 0, "R4 even parity accepted", status[2], 0);
    send(8'h55, 7, 1, ~^(7'h55), 1, 1);
    drain();
    check(status[2] == 1 && irq == 1, "R4 parity error flagged", status[2], 1);
    lsr_read();
    // R10
    check(status[5:1] == 0 && irq == 0, "R10 flags cleared on status read", status, 0);
    par_odd = 1'b1;
    send(8'h13, 7, 1, ~^(7'h13), 1, 1);
    drain();
    check(status[2] == 0, "R4 odd parity accepted", status[2], 0);
    par_en = 1'b0; par_odd = 1'b0; cfg_len = 2'd3;

    // R5: stop bit low
    send(8'h81, 8, 0, 0, 0, 1);
    drain();
    check(status[3] == 1 && status[4] == 0, "R5 framing flagged", status[4:3], 2'b01);
    lsr_read();

    // R1: start glitch rejected
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK * 12) @(negedge clk);
    check(status[0] == 0 && status[5:1] == 0, "R1 glitch ignored", status, 0);

    // R6: break, whole character low and beyond
    expq.push_back(8'h00);
    @(negedge clk); rxd = 1'b0;
    repeat (BITCLK * 14) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK * 2) @(negedge clk);
    drain();
    check(status[4] == 1 && status[3] == 0, "R6 break flagged not framing", status[4:3], 2'b10);
    check(expq.size() == 0 && status[0] == 0, "R6 single zero byte", expq.size(), 0);
    lsr_read();

    // R3: data ready held until every byte read
    mon_en = 1'b0;
    send(8'h61, 8, 0, 0, 1, 1);
    send(8'h62, 8, 0, 0, 1, 1);
    repeat (4) @(negedge clk);
    pop_compare("R3 first byte");
    check(status[0] == 1, "R3 ready stays with one left", status[0], 1);
    pop_compare("R3 second byte");
    check(status[0] == 0, "R3 ready clears when empty", status[0], 0);

    // R7: overrun with depth 4
    for (int i = 1; i <= 5; i++) send(8'(i), 8, 0, 0, 1, i <= 4);
    repeat (4) @(negedge clk);
    check(status[1] == 1, "R7 overrun flagged", status[1], 1);
    mon_en = 1'b1;
    drain();
    check(expq.size() == 0 && status[0] == 0, "R7 old bytes kept, new dropped", expq.size(), 0);
    lsr_read();

    // R8/R9: multidrop
    md_en = 1'b1; par_en = 1'b1;
    send(8'h12, 8, 1, 1, 1, 1);
    drain();
    check(status[5] == 1 && irq == 1 && status[2] == 0, "R8 address flagged", status, 8'h20);
    lsr_read();
    md_ignore = 1'b1;
    send(8'h77, 8, 1, 0, 1, 0);
    repeat (8) @(negedge clk);
    check(status[0] == 0 && irq == 0, "R9 data ignored", status, 0);
    send(8'h34, 8, 1, 1, 1, 1);
    drain();
    check(status[5] == 1, "R9 address still received", status[5], 1);
    lsr_read();
    md_ignore = 1'b0;
    send(8'h99, 8, 1, 0, 1, 1);
    drain();
    check(status[5:1] == 0, "R8 data byte no parity error", status[5:1], 0);

    summary();
    $finish;
  end
endmodule